// File: doc/BRIEF.md
# Programmable Input Pin Toggle Generator

This block is a bank of eighteen independent waveform generators, each of which owns one bit of a 24-bit image built from three 8-bit input ports. It is used to apply repeatable stimulus to pins that software or other logic later samples. For each generator, software writes a high duration, a low duration and a repeat count, then pulses that channel's configure strobe. From then on the generator flips its bit each time its delay runs out. After every flip it reloads the delay that matches the new level. It stops after a fixed number of flips.

Durations are counted in ticks of a clock-enable input. That input is normally the system clock divided by four. Conversion from real time to ticks is done outside the block. A per-channel clear strobe halts a generator at once and leaves its pin where it is. A synchronous reset halts every generator and drives the whole image low.

Top module: `pin_toggle_gen`

## Requirements
- R1: While `rst_n` is low, at each clock edge every channel becomes inactive and every bit of `port_img` goes to 0.
- R2: When a channel's delay expires, its own bit of `port_img` inverts at that clock edge. All other bits are unchanged by that expiry.
- R3: The first delay after a configure is the high duration if the pin is currently 1 and the low duration if it is 0. After each flip, the next delay is the high duration if the pin is now 1 and the low duration if it is now 0.
- R4: A channel configured with repeat count N flips exactly N+1 times and then goes inactive, holding its last level. An inactive channel's bit never changes.
- R5: A delay of D is counted only on clock edges where `tick` is 1, starting with the edge after the configure edge. The flip happens on the D-th such edge. A duration of 0 is treated as 1.
- R6: A configure on an active channel drops its pending flip and starts a fresh delay from the newly loaded values.
- R7: A clear stops the channel at the next edge and keeps its pin level. When configure and clear hit the same channel in the same cycle, clear wins.
- R8: Channel order and bit positions (A in bits 7:0, C in 15:8, D in 23:16) are as follows. Channels 0..3 drive bits 7, 2, 1 and 0. Channels 4..11 drive bits 8..15. Channels 12..17 drive bits 16..21. All other bits stay 0, so every channel at 1 gives 24'h3FFF87.
- R9: `active[i]` is 1 from the edge after a configure until the channel stops, through its final flip, a clear or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Clock enable that advances delays |
| cfg_stb | input | 18 | Per-channel configure strobe |
| clr_stb | input | 18 | Per-channel clear strobe |
| on_ticks | input | CNT_W | High duration in ticks |
| off_ticks | input | CNT_W | Low duration in ticks |
| rep_count | input | CNT_W | Number of flips after the first |
| port_img | output | 24 | Merged port image |
| active | output | 18 | Per-channel running flag |

## Verification
The bench goes after the off-by-one in the flip count. A design that tested the count after decrementing would stop one flip early and leave the pin at the wrong final level.

Zero durations are applied to check that they become one tick; a design without that fix would hang or wrap its counter. Idle `tick` cycles are inserted to check that delays are counted in ticks and not in clocks. Reconfigure and clear are issued in mid-delay, and configure and clear are issued together. A wrong priority there would leave the channel running. A reference model compares the full image and the `active` flags on every cycle under random traffic.

// File: rtl/pin_toggle_pkg.sv
// Package: shared sizes and the channel-to-bit placement of the toggle generator.
// Assumes three 8-bit ports laid out A, C, D from the least significant byte.
package pin_toggle_pkg;
    localparam int BITS_PER_PORT = 8;
    localparam int NUM_PORTS     = 3;
    localparam int IMG_W         = NUM_PORTS * BITS_PER_PORT;
    localparam int NUM_A_CH      = 4;
    localparam int NUM_C_CH      = 8;
    localparam int NUM_D_CH      = 6;
    localparam int NUM_CH        = NUM_A_CH + NUM_C_CH + NUM_D_CH;

    // Bit of the merged image driven by channel ch.
    function automatic int chan_bit(input int ch);
        if (ch == 0)
            return BITS_PER_PORT - 1;
        else if (ch < NUM_A_CH)
            return NUM_A_CH - 1 - ch;
        else if (ch < NUM_A_CH + NUM_C_CH)
            return BITS_PER_PORT + (ch - NUM_A_CH);
        else
            return 2 * BITS_PER_PORT + (ch - NUM_A_CH - NUM_C_CH);
    endfunction

    // Mask of every image bit that has a channel behind it.
    function automatic logic [IMG_W-1:0] driven_mask();
        logic [IMG_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_CH; i++) m[chan_bit(i)] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/pin_toggle_chan.sv
// Module: one toggle channel. Counts tick-qualified cycles down from the
// delay that matches its level, flips on expiry and reloads until the
// repeat count is spent. Assumes durations and repeat arrive with cfg.
module pin_toggle_chan #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cfg,
    input  logic             clr,
    input  logic [CNT_W-1:0] on_in,
    input  logic [CNT_W-1:0] off_in,
    input  logic [CNT_W-1:0] rep_in,
    output logic             level,
    output logic             running
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] on_q, off_q, left_q, rep_q;
    logic [CNT_W-1:0] on_eff, off_eff;

    // Clamp zero durations up to a single tick.
    always_comb begin
        on_eff  = (on_in  == '0) ? ONE : on_in;
        off_eff = (off_in == '0) ? ONE : off_in;
    end

    // Channel state: clear over configure over countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level   <= 1'b0;
            running <= 1'b0;
            on_q    <= ONE;
            off_q   <= ONE;
            left_q  <= ONE;
            rep_q   <= '0;
        end else if (clr) begin
            running <= 1'b0;
            rep_q   <= '0;
        end else if (cfg) begin
            on_q    <= on_eff;
            off_q   <= off_eff;
            rep_q   <= rep_in;
            running <= 1'b1;
            left_q  <= level ? on_eff : off_eff;
        end else if (running && tick) begin
            if (left_q <= ONE) begin
                level <= ~level;
                if (rep_q == '0) begin
                    running <= 1'b0;
                end else begin
                    rep_q  <= rep_q - ONE;
                    left_q <= level ? off_q : on_q;
                end
            end else begin
                left_q <= left_q - ONE;
            end
        end
    end
endmodule

// File: rtl/pin_toggle_merge.sv
// Module: places each channel level on its port bit; unmapped bits read 0.
// Assumes channel placement from the package function.
module pin_toggle_merge
    import pin_toggle_pkg::*;
(
    input  logic [NUM_CH-1:0] lvl,
    output logic [IMG_W-1:0]  img
);
    // Scatter channel levels into the image.
    always_comb begin
        img = '0;
        for (int i = 0; i < NUM_CH; i++) img[chan_bit(i)] = lvl[i];
    end
endmodule

// File: rtl/pin_toggle_gen.sv
// Module: top of the toggle generator bank. One channel per driven pin,
// shared duration inputs latched by whichever channels are strobed.
module pin_toggle_gen
    import pin_toggle_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [NUM_CH-1:0] cfg_stb,
    input  logic [NUM_CH-1:0] clr_stb,
    input  logic [CNT_W-1:0]  on_ticks,
    input  logic [CNT_W-1:0]  off_ticks,
    input  logic [CNT_W-1:0]  rep_count,
    output logic [IMG_W-1:0]  port_img,
    output logic [NUM_CH-1:0] active
);
    logic [NUM_CH-1:0] lvl;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pin_toggle_chan #(.CNT_W(CNT_W)) chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .cfg     (cfg_stb[g]),
            .clr     (clr_stb[g]),
            .on_in   (on_ticks),
            .off_in  (off_ticks),
            .rep_in  (rep_count),
            .level   (lvl[g]),
            .running (active[g])
        );
    end

    pin_toggle_merge merge_i (
        .lvl (lvl),
        .img (port_img)
    );
endmodule

// File: rtl/pin_toggle_chk.sv
// Module: protocol checker bound to the toggle generator top.
module pin_toggle_chk
    import pin_toggle_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [NUM_CH-1:0] cfg_stb,
    input logic [NUM_CH-1:0] clr_stb,
    input logic [IMG_W-1:0]  port_img,
    input logic [NUM_CH-1:0] active
);
    localparam logic [IMG_W-1:0] MASK = driven_mask();

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (port_img == '0 && active == '0));

    p_unmapped_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (port_img & ~MASK) == '0);

    p_no_tick_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(port_img));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_p
        localparam int B = chan_bit(g);

        p_clear_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
            clr_stb[g] |=> !active[g]);

        p_clear_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
            clr_stb[g] |=> $stable(port_img[B]));

        p_cfg_starts_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_stb[g] && !clr_stb[g]) |=> active[g]);

        p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !active[g] |=> $stable(port_img[B]));
    end
endmodule

bind pin_toggle_gen pin_toggle_chk chk_i (.*);

// File: tb/pin_toggle_gen_tb.sv
`timescale 1ns/1ps
module pin_toggle_gen_tb_top;
    localparam int NCH = 18;
    localparam int W   = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tick = 1'b1;
    logic [NCH-1:0] cfg_stb = '0;
    logic [NCH-1:0] clr_stb = '0;
    logic [W-1:0]   on_ticks = '0, off_ticks = '0, rep_count = '0;
    logic [23:0]    port_img;
    logic [NCH-1:0] active;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_en = 0;

    always #2.5 clk = ~clk;

    pin_toggle_gen #(.CNT_W(W)) dut_i (.*);

    // Bench-side placement table for R8.
    function automatic int bench_bit(input int ch);
        case (ch)
            0: return 7;
            1: return 2;
            2: return 1;
            3: return 0;
            default: return (ch < 12) ? ch + 4 : ch + 4;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    // Reference model, advanced at each clock edge from the requirements.
    logic          m_lvl [NCH];
    logic          m_act [NCH];
    logic [W-1:0]  m_on [NCH], m_off [NCH], m_left [NCH], m_rep [NCH];

    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n) begin
                m_lvl[c] = 0; m_act[c] = 0; m_rep[c] = 0; m_left[c] = 1;
                m_on[c] = 1; m_off[c] = 1;
            end else if (clr_stb[c]) begin
                m_act[c] = 0; m_rep[c] = 0;
            end else if (cfg_stb[c]) begin
                m_on[c]  = (on_ticks == 0) ? 1 : on_ticks;
                m_off[c] = (off_ticks == 0) ? 1 : off_ticks;
                m_rep[c] = rep_count;
                m_act[c] = 1;
                m_left[c] = m_lvl[c] ? m_on[c] : m_off[c];
            end else if (m_act[c] && tick) begin
                if (m_left[c] == 1) begin
                    m_lvl[c] = !m_lvl[c];
                    if (m_rep[c] == 0) m_act[c] = 0;
                    else begin
                        m_rep[c] = m_rep[c] - 1;
                        m_left[c] = m_lvl[c] ? m_on[c] : m_off[c];
                    end
                end else m_left[c] = m_left[c] - 1;
            end
        end
    end

    // Every-cycle comparison against the model (R2, R3, R4, R9).
    always @(negedge clk) begin
        if (cmp_en) begin
            logic [23:0] ei;
            logic [NCH-1:0] ea;
            ei = '0;
            for (int c = 0; c < NCH; c++) begin
                ei[bench_bit(c)] = m_lvl[c];
                ea[c] = m_act[c];
            end
            chk("R2 R3 R4 model port image", 64'(port_img), 64'(ei));
            chk("R9 model active flags", 64'(active), 64'(ea));
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; cfg_stb = '0; clr_stb = '0; tick = 1;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic cfg_one(input int ch, input int on, input int off, input int rep);
        on_ticks = W'(on); off_ticks = W'(off); rep_count = W'(rep);
        cfg_stb = '0; cfg_stb[ch] = 1'b1;
        @(negedge clk);
        cfg_stb = '0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        cmp_en = 1;
        chk("R1 reset image", 64'(port_img), 64'h0);
        chk("R1 reset active", 64'(active), 64'h0);

        // Scenario: ch4 (bit 8), high 3, low 2, repeat 2.
        cfg_one(4, 3, 2, 2);
        chk("R9 active after configure", 64'(active[4]), 64'h1);
        edges(1); chk("R3 low delay not yet done", 64'(port_img), 64'h0);
        edges(1); chk("R2 first flip only bit 8", 64'(port_img), 64'h000100);
        edges(2); chk("R3 high delay holding", 64'(port_img), 64'h000100);
        edges(1); chk("R3 flip after high delay", 64'(port_img), 64'h0);
        edges(2); chk("R4 third flip", 64'(port_img), 64'h000100);
        chk("R4 stopped after N+1 flips", 64'(active[4]), 64'h0);
        edges(3); chk("R4 final level held", 64'(port_img), 64'h000100);

        // Zero durations become one tick: ch0 (bit 7).
        do_reset();
        cfg_one(0, 0, 0, 1);
        edges(1); chk("R5 zero low duration is one tick", 64'(port_img), 64'h80);
        edges(1); chk("R5 zero high duration is one tick", 64'(port_img), 64'h0);
        chk("R5 zero-duration channel stopped", 64'(active[0]), 64'h0);

        // Tick gating: ch12 (bit 16).
        do_reset();
        tick = 0;
        cfg_one(12, 5, 2, 0);
        edges(5); chk("R5 no count without tick", 64'(port_img), 64'h0);
        chk("R9 still active while waiting", 64'(active[12]), 64'h1);
        tick = 1;
        edges(1); chk("R5 one tick counted", 64'(port_img), 64'h0);
        edges(1); chk("R5 flip on second tick", 64'(port_img), 64'h010000);
        chk("R4 repeat zero gives one flip", 64'(active[12]), 64'h0);

        // Clear holds level; clear beats configure: ch5 (bit 9).
        do_reset();
        cfg_one(5, 9, 1, 5);
        edges(1); chk("R2 ch5 high", 64'(port_img), 64'h000200);
        clr_stb[5] = 1; edges(1); clr_stb = '0;
        chk("R7 clear stops channel", 64'(active[5]), 64'h0);
        edges(20); chk("R7 level kept after clear", 64'(port_img), 64'h000200);
        on_ticks = 1; off_ticks = 1; rep_count = 3;
        cfg_stb[5] = 1; clr_stb[5] = 1; edges(1); cfg_stb = '0; clr_stb = '0;
        chk("R7 clear wins over configure", 64'(active[5]), 64'h0);
        edges(4); chk("R7 no flip after combined strobe", 64'(port_img), 64'h000200);

        // Reconfigure mid-delay: ch6 (bit 10).
        do_reset();
        cfg_one(6, 4, 10, 0);
        edges(3);
        cfg_one(6, 4, 2, 0);
        edges(1); chk("R6 restarted delay pending", 64'(port_img), 64'h0);
        edges(1); chk("R6 flip on new delay", 64'(port_img), 64'h000400);

        // All channels at once for placement.
        do_reset();
        on_ticks = 1; off_ticks = 1; rep_count = 0;
        cfg_stb = '1; edges(1); cfg_stb = '0;
        edges(1); chk("R8 full placement", 64'(port_img), 64'h3FFF87);
        chk("R9 all stopped", 64'(active), 64'h0);

        // Constrained random traffic checked by the model.
        do_reset();
        for (int k = 0; k < 4000; k++) begin
            tick = ($urandom % 4) != 0;
            for (int c = 0; c < NCH; c++) begin
                cfg_stb[c] = ($urandom % 16) == 0;
                clr_stb[c] = ($urandom % 40) == 0;
            end
            on_ticks  = W'($urandom % 6);
            off_ticks = W'($urandom % 6);
            rep_count = W'($urandom % 4);
            if (k % 997 == 500) rst_n = 0; else rst_n = 1;
            @(negedge clk);
        end
        cfg_stb = '0; clr_stb = '0; rst_n = 1;
        edges(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule